// File: doc/BRIEF.md
# Iterative Factorial Unit with Busy Flag

This block computes the factorial of a 32-bit operand that software writes into a single operand/result register. The product wraps modulo 2^32. A write to that register while the unit is idle loads the operand and starts an iterative loop. The loop does one multiply per clock cycle while a down-counter is still above zero. When the loop ends, the result overwrites the operand in the same register.

A status register reports a read-only computing flag in bit 0. It also holds an interrupt-enable bit in bit 7, which software controls. If the enable is set when a computation ends, the unit raises a one-cycle request on interrupt line 0. Aggregating that request with other sources happens outside the block.

Software starts a job by writing the operand. It then polls bit 0 of the status register, or waits for the request, before it reads the result. Writes that arrive while the loop runs are dropped without notice.

Top module: `fact_unit`

## Requirements
- R1: After reset the operand/result register reads 0, the status register reads 0x00 and `irq_req` is low.
- R2: An operand write while idle loads the operand into the register and sets status bit 0 (value 0x01) from the next clock edge on.
- R3: An operand write while status bit 0 is set is ignored: the register content and the final result are unaffected.
- R4: The result is n·(n−1)·…·1 taken modulo 2^32, and an operand of 0 gives 1.
- R5: For operand n, status bit 0 stays set for exactly n+1 cycles after the write edge. The result appears in the register on the same edge that clears the bit.
- R6: While status bit 0 is set, the operand/result register reads the loaded operand, never a partial product.
- R7: A status write copies only bit 7 of the written data into the interrupt enable. Bit 0 cannot be written, and bits 6 to 1 always read 0.
- R8: When a computation ends with the enable set, `irq_req` is high for exactly the one cycle in which status bit 0 first reads 0. With the enable clear, `irq_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_wr | input | 1 | Write strobe for the operand/result register |
| opnd_wdata | input | 32 | Operand to load |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status write data; only bit 7 is used |
| opnd_rdata | output | 32 | Operand/result register contents |
| stat_rdata | output | 8 | Status: bit 0 computing, bit 7 interrupt enable |
| irq_req | output | 1 | One-cycle request to raise interrupt bit 0 on completion |

## Verification
The computing flag is due one edge after an operand write. The result and the flag's clearing are due n+1 edges after that write, and the completion request follows in the same cycle. The bench drives every input on the falling edge and samples on the falling edge. It counts falling edges from the write until the flag drops, compares that count with n+1, and checks the request both in that cycle and in the next. Dropped writes and mid-run reads are placed at known cycle offsets within a run whose length is known, so each is sampled while the flag is still set.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int STAT_W   = 8;
  localparam int BUSY_BIT = 0;
  localparam int IE_BIT   = 7;
endpackage

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] start_val,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] prod,
  output logic [DATA_W-1:0] cnt
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] next_prod;

  assign next_prod = prod * cnt;
  assign done      = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      prod <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= start_val;
      prod <= ONE;
    end else if (busy) begin
      if (cnt != '0) begin
        prod <= next_prod;
        cnt  <= cnt - ONE;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> (busy && cnt == ($past(cnt) - ONE))); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy); // R5
endmodule

// File: rtl/fact_status.sv
module fact_status
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              busy,
  output logic              irq_en,
  output logic [STAT_W-1:0] stat_rdata
);
  always_ff @(posedge clk) begin
    if (rst)          irq_en <= 1'b0;
    else if (stat_wr) irq_en <= stat_wdata[IE_BIT];
  end

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[BUSY_BIT] = busy;
    stat_rdata[IE_BIT]   = irq_en;
  end

  AST_IE_WRITE: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (irq_en == $past(stat_wdata[IE_BIT]))); // R7
endmodule

// File: rtl/fact_unit.sv
module fact_unit
  import fact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opnd_wr,
  input  logic [DATA_W-1:0] opnd_wdata,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [DATA_W-1:0] opnd_rdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq_req
);
  logic              busy, done, start, irq_en;
  logic [DATA_W-1:0] prod, cnt, hold_q;

  assign start      = opnd_wr && !busy;
  assign opnd_rdata = hold_q;

  fact_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .start_val(opnd_wdata),
    .busy(busy), .done(done), .prod(prod), .cnt(cnt)
  );

  fact_status u_status (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .busy(busy), .irq_en(irq_en), .stat_rdata(stat_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      irq_req <= 1'b0;
    end else begin
      irq_req <= done && irq_en;
      if (start)     hold_q <= opnd_wdata;
      else if (done) hold_q <= prod;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (opnd_wr && !busy) |=> (busy && hold_q == $past(opnd_wdata))); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (opnd_wr && busy && cnt != '0) |=> (hold_q == $past(hold_q))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(hold_q)); // R6
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $fell(busy)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (irq_req == $past(irq_en))); // R8
endmodule

// File: tb/fact_unit_test.sv
module fact_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [31:0] n;
    logic        ie;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'd0, 1'b1}, '{32'd1, 1'b0}, '{32'd2, 1'b1}, '{32'd5, 1'b1},
    '{32'd7, 1'b0}, '{32'd10, 1'b1}, '{32'd12, 1'b1}, '{32'd13, 1'b0},
    '{32'd20, 1'b1}, '{32'd34, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opnd_wr = 1'b0;
  logic [31:0] opnd_wdata = '0;
  logic        stat_wr = 1'b0;
  logic [7:0]  stat_wdata = '0;
  logic [31:0] opnd_rdata;
  logic [7:0]  stat_rdata;
  logic        irq_req;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fact_unit uut (
    .clk(clk), .rst(rst), .opnd_wr(opnd_wr), .opnd_wdata(opnd_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .opnd_rdata(opnd_rdata),
    .stat_rdata(stat_rdata), .irq_req(irq_req)
  );

  function automatic logic [31:0] ref_fact(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int i = 1; i <= int'(n); i++) r = r * 32'(i);
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_opnd(input logic [31:0] v);
    opnd_wr = 1'b1; opnd_wdata = v;
    @(negedge clk);
    opnd_wr = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  // Count cycles until the busy flag drops; returns the count.
  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (stat_rdata[0] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(opnd_rdata == 32'd0, "R1 result", opnd_rdata, 32'd0);
    chk(stat_rdata == 8'h00, "R1 status", {24'd0, stat_rdata}, 32'd0);
    chk(irq_req == 1'b0, "R1 irq", {31'd0, irq_req}, 32'd0);

    // Vector table: R2 R4 R5 R8
    for (int k = 0; k < NV; k++) begin
      wr_stat({VECS[k].ie, 7'd0});
      wr_opnd(VECS[k].n);
      chk(stat_rdata[0] == 1'b1, "R2 busy set", {24'd0, stat_rdata}, 32'h1);
      chk(opnd_rdata == VECS[k].n, "R2 operand loaded", opnd_rdata, VECS[k].n);
      wait_idle(cyc);
      chk(cyc == int'(VECS[k].n) + 1, "R5 latency", 32'(cyc), VECS[k].n + 32'd1);
      chk(opnd_rdata == ref_fact(VECS[k].n), "R4 result", opnd_rdata, ref_fact(VECS[k].n));
      chk(irq_req == VECS[k].ie, "R8 irq at end", {31'd0, irq_req}, {31'd0, VECS[k].ie});
      @(negedge clk);
      chk(irq_req == 1'b0, "R8 irq one cycle", {31'd0, irq_req}, 32'd0);
    end

    // R7: only bit 7 writable, busy bit read-only, others read 0
    wr_stat(8'hFF);
    chk(stat_rdata == 8'h80, "R7 write FF", {24'd0, stat_rdata}, 32'h80);
    wr_stat(8'h7F);
    chk(stat_rdata == 8'h00, "R7 write 7F", {24'd0, stat_rdata}, 32'h0);

    // R3 / R6: write during busy dropped, register holds operand mid-run
    wr_stat(8'h80);
    wr_opnd(32'd6);
    @(negedge clk);
    wr_opnd(32'd9);
    chk(stat_rdata[0] == 1'b1, "R3 still busy", {24'd0, stat_rdata}, 32'h81);
    chk(opnd_rdata == 32'd6, "R6 mid-run read", opnd_rdata, 32'd6);
    @(negedge clk);
    chk(opnd_rdata == 32'd6, "R3 operand kept", opnd_rdata, 32'd6);
    wait_idle(cyc);
    chk(opnd_rdata == 32'd720, "R3 result unaffected", opnd_rdata, 32'd720);
    chk(irq_req == 1'b1, "R8 irq after dropped write", {31'd0, irq_req}, 32'd1);

    // R8: enable cleared during run suppresses the request
    wr_opnd(32'd4);
    wr_stat(8'h00);
    wait_idle(cyc);
    chk(opnd_rdata == 32'd24, "R4 result 4", opnd_rdata, 32'd24);
    chk(irq_req == 1'b0, "R8 no irq when disabled", {31'd0, irq_req}, 32'd0);

    // R7: busy bit cannot be set by a status write while idle
    wr_stat(8'h01);
    @(negedge clk);
    chk(stat_rdata == 8'h00, "R7 busy not writable", {24'd0, stat_rdata}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule